// File: doc/BRIEF.md
# Interrupt Non-secure Access Permission Checker

This block keeps one 2-bit non-secure permission level for each interrupt of a distributor. The levels sit in a bank of 32-bit control registers that only secure software may read or write. Other parts of the distributor use the block to ask whether a non-secure request on a given interrupt may go ahead. The register port is a plain strobe port with combinational read data.

The query port is combinational. It takes an interrupt ID, the security group of that interrupt and an operation class, and it returns allow or deny. The levels are tiers that build on one another. Level 1 opens set-pending and software-interrupt generation. Level 2 adds clear-pending and active-state reads. Level 3 adds routing and target access. In the first register, which covers software-generated interrupts, a level 3 write is stored as level 2.

Top module: `nsac_perm_bank`

## Requirements
- R1: After reset, every register of the bank reads as 0 on a secure read.
- R2: Register n sits at byte address 0xE00 + 4n, for n from 0 to NUM_REGS-1. Bits [2x+1:2x] of register n hold the level of interrupt 16n + x. A secure read returns the stored levels. An access whose address is misaligned or outside the window reads 0 and changes no level.
- R3: When reg_secure is 0, a read returns 0 and a write changes no level.
- R4: When sec_disable is 1, every register reads 0 and writes change no level.
- R5: Register 1 (address 0xE04) always reads 0 and ignores writes. Queries for interrupts 16 to 31 with q_irq_secure=1 are denied.
- R6: In register 0, a field written with 3 is stored and read back as 2, and it grants exactly what level 2 grants.
- R7: For a secure interrupt, q_op 0 (set-pending) and 4 (software-interrupt send) are allowed at level 1 or higher. q_op 1 (clear-pending) and 2 (active-state read) are allowed at level 2 or higher. q_op 3 (routing/target) is allowed only at level 3. q_op values 5 to 7 are denied.
- R8: A query with q_irq_secure=0 and q_id not above MAX_ID is allowed, whatever the stored level.
- R9: Fields of interrupts above MAX_ID read 0 and ignore writes. Any query with q_id above MAX_ID is denied.
- R10: A query is answered combinationally from the stored levels. A register write changes q_allow from the cycle after the clock edge that takes the write strobe.
- R11: Queries use the stored levels whatever the value of sec_disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_disable | input | 1 | Global security-disable control; 1 makes the bank read 0 and ignore writes |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_secure | input | 1 | Access is made by secure software |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, 0 when no read is accepted |
| q_id | input | 10 | Interrupt ID being queried |
| q_irq_secure | input | 1 | Queried interrupt belongs to a secure group |
| q_op | input | 3 | Operation class (0 set-pend, 1 clr-pend, 2 active read, 3 routing, 4 SGI send) |
| q_allow | output | 1 | 1 = the operation is permitted |

## Verification
The assertions take the inputs to be stable around the rising clock edge and take reset to be asserted once before use. The register-port assertions also treat every strobe as one access in one cycle. The bench changes its inputs only one time unit after a rising edge. It compares read data and q_allow against its behavioural model at the falling edge. It updates the model at the following rising edge, so a write and a query in the same cycle show the old level first. The random traffic uses every address in and around the window, both security flags, the disable bit and all eight operation codes.

// File: rtl/nsac_pkg.sv
package nsac_pkg;
  typedef enum logic [2:0] {
    OP_SETPEND = 3'd0,
    OP_CLRPEND = 3'd1,
    OP_ACTRD   = 3'd2,
    OP_ROUTE   = 3'd3,
    OP_SGI     = 3'd4
  } perm_op_e;

  localparam int unsigned FIELDS_PER_REG = 16;
  localparam logic [1:0]  LVL_NONE  = 2'd0;
  localparam logic [1:0]  LVL_SET   = 2'd1;
  localparam logic [1:0]  LVL_CLEAR = 2'd2;
  localparam logic [1:0]  LVL_ROUTE = 2'd3;
endpackage

// File: rtl/nsac_addr_decode.sv
module nsac_addr_decode #(
  parameter int unsigned NUM_REGS = 64,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS),
  parameter logic [ADDR_W-1:0] BASE = 'hE00
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned SPAN = 4 * NUM_REGS;

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr - BASE;
    hit    = (addr >= BASE) && (offset < ADDR_W'(SPAN)) && (addr[1:0] == 2'b00);
    idx    = offset[IDX_W+1:2];
  end
endmodule

// File: rtl/nsac_level_store.sv
module nsac_level_store
  import nsac_pkg::*;
#(
  parameter int unsigned NUM_REGS = 64,
  parameter int unsigned MAX_ID   = 1019,
  parameter int unsigned IDX_W    = $clog2(NUM_REGS),
  parameter int unsigned NF       = NUM_REGS * FIELDS_PER_REG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]     wr_data,
  output logic [2*NF-1:0] lvl_flat
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar x = 0; x < FIELDS_PER_REG; x++) begin : g_fld
      localparam int unsigned FID = r * FIELDS_PER_REG + x;
      if (FID <= MAX_ID && r != 1) begin : g_impl
        logic [1:0] lvl_q;
        logic [1:0] wr_val;
        always_comb begin
          wr_val = wr_data[2*x +: 2];
          if (r == 0 && wr_val == LVL_ROUTE) wr_val = LVL_CLEAR;
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                               lvl_q <= LVL_NONE;
          else if (wr_en && wr_idx == IDX_W'(r))    lvl_q <= wr_val;
        end
        assign lvl_flat[2*FID +: 2] = lvl_q;
      end else begin : g_raz
        assign lvl_flat[2*FID +: 2] = LVL_NONE;
      end
    end
  end
endmodule

// File: rtl/nsac_perm_check.sv
module nsac_perm_check
  import nsac_pkg::*;
#(
  parameter int unsigned NF     = 1024,
  parameter int unsigned MAX_ID = 1019,
  parameter int unsigned IDW    = $clog2(NF)
) (
  input  logic [2*NF-1:0] lvl_flat,
  input  logic [IDW-1:0]  q_id,
  input  logic            q_irq_secure,
  input  logic [2:0]      q_op,
  output logic            q_allow
);
  logic [1:0] level;

  always_comb begin
    level = lvl_flat[2*int'(q_id) +: 2];
    if (int'(q_id) > int'(MAX_ID)) begin
      q_allow = 1'b0;
    end else if (!q_irq_secure) begin
      q_allow = 1'b1;
    end else begin
      unique case (q_op)
        OP_SETPEND, OP_SGI:  q_allow = (level >= LVL_SET);
        OP_CLRPEND, OP_ACTRD: q_allow = (level >= LVL_CLEAR);
        OP_ROUTE:            q_allow = (level == LVL_ROUTE);
        default:             q_allow = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/nsac_perm_bank.sv
module nsac_perm_bank
  import nsac_pkg::*;
#(
  parameter int unsigned NUM_REGS = 64,
  parameter int unsigned MAX_ID   = 1019,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_disable,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic              reg_secure,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [$clog2(NUM_REGS*FIELDS_PER_REG)-1:0] q_id,
  input  logic              q_irq_secure,
  input  logic [2:0]        q_op,
  output logic              q_allow
);
  localparam int unsigned NF    = NUM_REGS * FIELDS_PER_REG;
  localparam int unsigned IDW   = $clog2(NF);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [2*NF-1:0]  lvl_flat;
  logic             access_ok;
  logic             wr_en;
  logic [31:0]      rd_word;

  nsac_addr_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr (reg_addr),
    .hit  (hit),
    .idx  (idx)
  );

  assign access_ok = reg_en && reg_secure && !sec_disable && hit;
  assign wr_en     = access_ok && reg_we;

  nsac_level_store #(.NUM_REGS(NUM_REGS), .MAX_ID(MAX_ID), .IDX_W(IDX_W), .NF(NF)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (idx),
    .wr_data  (reg_wdata),
    .lvl_flat (lvl_flat)
  );

  always_comb begin
    rd_word   = lvl_flat[32*int'(idx) +: 32];
    reg_rdata = (access_ok && !reg_we) ? rd_word : 32'h0;
  end

  nsac_perm_check #(.NF(NF), .MAX_ID(MAX_ID), .IDW(IDW)) u_chk (
    .lvl_flat     (lvl_flat),
    .q_id         (q_id),
    .q_irq_secure (q_irq_secure),
    .q_op         (q_op),
    .q_allow      (q_allow)
  );

  // R3
  ns_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && !reg_secure) |=> $stable(lvl_flat));

  // R4
  disable_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && sec_disable) |=> $stable(lvl_flat));

  // R4
  disable_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && sec_disable) |-> (reg_rdata == 32'h0));

  // R5
  ppi_reg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_we && reg_addr == ADDR_W'('hE04)) |-> (reg_rdata == 32'h0));

  // R6
  sgi_no_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_irq_secure && int'(q_id) < 16 && q_op == OP_ROUTE) |-> !q_allow);

  // R8
  nonsecure_irq_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_irq_secure && int'(q_id) <= int'(MAX_ID)) |-> q_allow);

  // R9
  above_max_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(q_id) > int'(MAX_ID)) |-> !q_allow);
endmodule

// File: tb/test_nsac_perm_bank.sv
`timescale 1ns/1ps
module test_nsac_perm_bank;
  localparam int MAXID = 1019;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_disable = 1'b0;
  logic        reg_en = 1'b0, reg_we = 1'b0, reg_secure = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [9:0]  q_id = '0;
  logic        q_irq_secure = 1'b0;
  logic [2:0]  q_op = '0;
  logic        q_allow;

  int checks = 0, failures = 0;
  int lvl [1024];

  always #2.5 clk = ~clk;

  nsac_perm_bank i_nsac_perm_bank (
    .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable),
    .reg_en(reg_en), .reg_we(reg_we), .reg_secure(reg_secure),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .q_id(q_id), .q_irq_secure(q_irq_secure), .q_op(q_op), .q_allow(q_allow)
  );

  function automatic bit in_window(logic [11:0] a);
    return (a >= 12'hE00) && (a < 12'hF00) && (a[1:0] == 2'b00);
  endfunction

  function automatic bit impl(int id);
    return (id <= MAXID) && (id / 16 != 1);
  endfunction

  function automatic logic [31:0] m_read();
    logic [31:0] w = '0;
    if (!(reg_en && !reg_we && reg_secure && !sec_disable && in_window(reg_addr))) return '0;
    for (int x = 0; x < 16; x++) w[2*x +: 2] = 2'(lvl[(int'(reg_addr) - 'hE00) / 4 * 16 + x]);
    return w;
  endfunction

  function automatic logic m_allow();
    int l;
    if (int'(q_id) > MAXID) return 1'b0;
    if (!q_irq_secure) return 1'b1;
    l = lvl[q_id];
    case (q_op)
      3'd0, 3'd4: return l >= 1;
      3'd1, 3'd2: return l >= 2;
      3'd3:       return l == 3;
      default:    return 1'b0;
    endcase
  endfunction

  task automatic m_update();
    int n, v;
    if (reg_en && reg_we && reg_secure && !sec_disable && in_window(reg_addr)) begin
      n = (int'(reg_addr) - 'hE00) / 4;
      for (int x = 0; x < 16; x++) begin
        v = int'(reg_wdata[2*x +: 2]);
        if (n == 0 && v == 3) v = 2;
        if (impl(n * 16 + x)) lvl[n * 16 + x] = v;
      end
    end
  endtask

  task automatic cyc(input logic en, input logic we, input logic sec, input logic dis,
                     input logic [11:0] addr, input logic [31:0] wd,
                     input int qid, input logic qsec, input int op, input string tag);
    logic [31:0] er;
    logic ea;
    reg_en = en; reg_we = we; reg_secure = sec; sec_disable = dis;
    reg_addr = addr; reg_wdata = wd;
    q_id = 10'(qid); q_irq_secure = qsec; q_op = 3'(op);
    @(negedge clk);
    er = m_read();
    ea = m_allow();
    checks++;
    if (reg_rdata !== er) begin
      failures++;
      $display("FAIL %s rdata addr=%h act=%h exp=%h", tag, addr, reg_rdata, er);
    end
    checks++;
    if (q_allow !== ea) begin
      failures++;
      $display("FAIL %s q_allow id=%0d op=%0d act=%b exp=%b", tag, qid, op, q_allow, ea);
    end
    @(posedge clk);
    m_update();
    #1;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    cyc(1, 0, 1, 0, a, '0, 0, 0, 0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(1, 1, 1, 0, a, d, 0, 0, 0, tag);
  endtask

  task automatic query(input int id, input logic s, input int op, input string tag);
    cyc(0, 0, 1, 0, 12'h0, '0, id, s, op, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) lvl[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int n = 0; n < 64; n++) rd(12'(12'hE00 + 4 * n), "R1");

    wr(12'hE08, 32'hE4E4_1B1B, "R2");
    rd(12'hE08, "R2");
    wr(12'hEA0, 32'h3C96_A55A, "R2");
    rd(12'hEA0, "R2");
    wr(12'hE09, 32'hFFFF_FFFF, "R2");
    rd(12'hE08, "R2");
    wr(12'hD00, 32'hFFFF_FFFF, "R2");
    rd(12'hD00, "R2");
    rd(12'hF00, "R2");

    for (int id = 32; id < 48; id++)
      for (int op = 0; op < 8; op++) query(id, 1, op, "R7");
    for (int id = 32; id < 48; id += 5) query(id, 0, 3, "R8");

    cyc(1, 1, 0, 0, 12'hE08, 32'h0, 0, 0, 0, "R3");
    cyc(1, 0, 0, 0, 12'hE08, 32'h0, 0, 0, 0, "R3");
    rd(12'hE08, "R3");

    cyc(1, 1, 1, 1, 12'hE08, 32'h0, 0, 0, 0, "R4");
    cyc(1, 0, 1, 1, 12'hE08, 32'h0, 0, 0, 0, "R4");
    rd(12'hE08, "R4");
    cyc(0, 0, 1, 1, 12'h0, 32'h0, 33, 1, 3, "R11");
    cyc(0, 0, 1, 1, 12'h0, 32'h0, 35, 1, 0, "R11");

    wr(12'hE04, 32'hFFFF_FFFF, "R5");
    rd(12'hE04, "R5");
    for (int id = 16; id < 32; id += 3) query(id, 1, 0, "R5");

    wr(12'hE00, 32'hFFFF_FFFF, "R6");
    rd(12'hE00, "R6");
    query(5, 1, 3, "R6");
    query(5, 1, 1, "R6");
    query(5, 1, 2, "R6");

    wr(12'hEFC, 32'hFFFF_FFFF, "R9");
    rd(12'hEFC, "R9");
    query(1019, 1, 3, "R9");
    query(1020, 1, 3, "R9");
    query(1023, 0, 0, "R9");

    cyc(1, 1, 1, 0, 12'hE28, 32'h0000_0003, 160, 1, 3, "R10");
    query(160, 1, 3, "R10");

    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      a = 12'(12'hDF8 + ($urandom % 272));
      if ($urandom % 4 != 0) a[1:0] = 2'b00;
      cyc(1'($urandom % 4 != 0), 1'($urandom % 2), 1'($urandom % 8 != 0),
          1'($urandom % 10 == 0), a, $urandom,
          int'($urandom % 1024), 1'($urandom % 4 != 0), int'($urandom % 8), "R7");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule